// File: doc/BRIEF.md
# Delayed-Parity Command Error Checker

This block watches a 28-bit command/address word that is registered once per clock and checks it against an even-parity bit. The parity bit reaches the block one clock after the word it protects, so the word is carried for one extra stage before the two are combined. A static configuration input picks one of two sets of 22 covered bit positions. The remaining six positions carry per-rank signals such as clock enables, termination controls and chip selects, and they never take part in the check.

The result is an active-low error flag. Once it asserts, it stays low for at least two cycles, and longer while errors keep arriving. It does not change while both chip selects are deasserted. When the gate enable is also high, the block is in a low-power state: the input word register holds its last value, and an error raised just before that state is still shown for the whole low-power stretch plus two more cycles.

The reset is active-low and is sampled on the clock edge. It clears every stage and returns the flag to its idle high level.

Top module: `cmd_parity_monitor`

## Requirements
- R1: With `rst_n` low at a rising edge, `err_n` is 1 after that edge, and no error that was pending or held before the reset appears afterwards.
- R2: The check passes when the covered bits of a word and the parity bit paired with it hold an even number of ones in total. When the count is odd, an error is raised.
- R3: The parity bit sampled at edge n+1 is paired with the word sampled at edge n, not with the word sampled at the same edge.
- R4: An error in the word sampled at edge n drives `err_n` low after edge n+2, and not earlier.
- R5: With `cfg_sel`=0, the covered bit positions are 1-5, 7, 9-12 and 17-28, where position p is `cmd_in[p-1]`. Positions 6, 8 and 13-16 are ignored.
- R6: With `cfg_sel`=1, the covered bit positions are 1-12, 17-20, 22 and 24-28, where position p is `cmd_in[p-1]`. Positions 13-16, 21 and 23 are ignored.
- R7: Once `err_n` falls, it stays low for at least two cycles. With no further error and no freeze, it returns high after the second update edge.
- R8: Back-to-back errors keep `err_n` low without a break. It returns high two update edges after the last error.
- R9: At any edge where `cs0_n` and `cs1_n` are both 1, `err_n` keeps its value: it neither asserts on a new error nor releases.
- R10: If an error drives `err_n` low on the edge just before low-power mode (`gate_en`, `cs0_n` and `cs1_n` all 1), `err_n` stays low for the whole low-power period and for the first cycle after it. It goes high after the second non-frozen edge.
- R11: At an edge in low-power mode, the input word register keeps its previous word. The parity check then covers the held word, not the word present on `cmd_in`.
- R12: With `gate_en` at 0, the word is captured at every edge, even when both chip selects are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| cfg_sel | input | 1 | Static choice between the two covered-bit sets |
| cmd_in | input | 28 | Command/address word |
| par_in | input | 1 | Even-parity bit for the word sampled one edge earlier |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| gate_en | input | 1 | Enables input-word gating while both chip selects are high |
| err_n | output | 1 | Registered parity-error flag, active low |

## Verification
A single-bit sweep over all 28 positions in both configurations catches a mask with a wrong or shifted bit: such a design would flag an excluded position or miss a covered one. A pairing probe catches a design that joins parity to the same-edge word, because that design would report the wrong word. The probe and the sweep together catch a design that is off by one stage: it would flag an edge early or late. Directed sequences cover:
- the two-cycle minimum hold, where a counter off by one releases too early or holds too long;
- a burst of errors, where the flag must not flicker between them;
- a freeze that would otherwise hide both an assertion and a release;
- an error just before low-power entry, where a design that kept counting during the freeze releases early;
- the held-word case, where a design that kept capturing during low power raises a false error, and the ungated case, where the word must still be captured.

A long randomized stretch with chip-select and gate activity is then compared every cycle against a model built from the requirements.

// File: rtl/cmdpar_pkg.sv
// Shared constants and helpers for the delayed-parity command checker.
// Assumes bit position p of the command word is carried on index p-1.
package cmdpar_pkg;

    localparam int CMD_W = 28;

    // Covered positions for configuration 0: all but 6, 8 and 13-16.
    localparam logic [CMD_W-1:0] COVER_CFG0 = 28'hFFF0F5F;
    // Covered positions for configuration 1: all but 13-16, 21 and 23.
    localparam logic [CMD_W-1:0] COVER_CFG1 = 28'hFAF0FFF;

    // Returns 1 when the masked word has an odd number of ones.
    function automatic logic odd_weight(input logic [CMD_W-1:0] word,
                                        input logic [CMD_W-1:0] keep);
        return ^(word & keep);
    endfunction

endpackage

// File: rtl/cmdpar_capture.sv
// Two-stage input pipeline. Stage one registers the command word and holds
// it while low-power gating is active. Stage two delays that word by one
// more edge so that it lines up with the parity bit, which is registered
// alongside it. Assumes a synchronous active-low reset.
module cmdpar_capture #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cmd_in,
    input  logic         par_in,
    input  logic         lp_gate,
    output logic [W-1:0] word_al,
    output logic         par_al
);

    logic [W-1:0] word_s1;

    // Stage one: capture the word unless low-power gating holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_s1 <= '0;
        end else if (!lp_gate) begin
            word_s1 <= cmd_in;
        end
    end

    // Stage two: realign the word with its late-arriving parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_al <= '0;
            par_al  <= 1'b0;
        end else begin
            word_al <= word_s1;
            par_al  <= par_in;
        end
    end

endmodule

// File: rtl/cmdpar_parity_eval.sv
// Combinational even-parity check of an aligned word and parity bit.
// The covered-bit mask is built per bit from the static configuration
// input. Assumes cfg_sel does not change during normal operation.
module cmdpar_parity_eval #(
    parameter int             W     = 28,
    parameter logic [W-1:0]   MASK0 = '1,
    parameter logic [W-1:0]   MASK1 = '1
) (
    input  logic [W-1:0] word_al,
    input  logic         par_al,
    input  logic         cfg_sel,
    output logic         err_seen
);

    logic [W-1:0] keep;

    // Per-bit mask selection between the two coverage sets.
    for (genvar i = 0; i < W; i++) begin : g_keep
        assign keep[i] = cfg_sel ? MASK1[i] : MASK0[i];
    end

    // Odd total weight of covered bits plus parity means an error.
    always_comb begin
        err_seen = cmdpar_pkg::odd_weight(word_al, keep) ^ par_al;
    end

endmodule

// File: rtl/cmdpar_hold.sv
// Error-flag hold logic. A down-counter is reloaded on each detected error
// and counts down on non-frozen edges. The flag is low while the counter is
// non-zero. Freeze stops all updates. Assumes a synchronous active-low
// reset.
module cmdpar_hold #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_seen,
    input  logic freeze,
    output logic err_n
);

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // Next hold count: reload on an error, else count down toward zero.
    always_comb begin
        cnt_nx = cnt_q;
        if (!freeze) begin
            if (err_seen) begin
                cnt_nx = RELOAD;
            end else if (cnt_q != '0) begin
                cnt_nx = cnt_q - 1'b1;
            end
        end
    end

    // Register the count and the active-low flag derived from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_n <= 1'b1;
        end else begin
            cnt_q <= cnt_nx;
            err_n <= (cnt_nx == '0);
        end
    end

endmodule

// File: rtl/cmd_parity_monitor.sv
// Top of the delayed-parity command checker. It chains the capture
// pipeline, the parity evaluator and the hold logic. Both chip selects high
// freeze the flag. Adding gate_en also holds the input word (low-power
// mode). Assumes cfg_sel is static.
module cmd_parity_monitor #(
    parameter int                    CMD_W       = cmdpar_pkg::CMD_W,
    parameter int                    HOLD_CYCLES = 2,
    parameter logic [CMD_W-1:0]      COVER0      = cmdpar_pkg::COVER_CFG0,
    parameter logic [CMD_W-1:0]      COVER1      = cmdpar_pkg::COVER_CFG1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel,
    input  logic [CMD_W-1:0] cmd_in,
    input  logic             par_in,
    input  logic             cs0_n,
    input  logic             cs1_n,
    input  logic             gate_en,
    output logic             err_n
);

    logic             freeze;
    logic             lp_gate;
    logic [CMD_W-1:0] word_al;
    logic             par_al;
    logic             err_seen;

    // Freeze when neither rank is selected; gate the input in low power.
    always_comb begin
        freeze  = cs0_n & cs1_n;
        lp_gate = freeze & gate_en;
    end

    cmdpar_capture #(.W(CMD_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_in  (cmd_in),
        .par_in  (par_in),
        .lp_gate (lp_gate),
        .word_al (word_al),
        .par_al  (par_al)
    );

    cmdpar_parity_eval #(.W(CMD_W), .MASK0(COVER0), .MASK1(COVER1)) u_eval (
        .word_al  (word_al),
        .par_al   (par_al),
        .cfg_sel  (cfg_sel),
        .err_seen (err_seen)
    );

    cmdpar_hold #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_seen (err_seen),
        .freeze   (freeze),
        .err_n    (err_n)
    );

endmodule

// File: rtl/cmd_parity_monitor_sva.sv
// Property checker for the delayed-parity command checker, bound to the top.
module cmd_parity_monitor_sva (
    input logic clk,
    input logic rst_n,
    input logic cs0_n,
    input logic cs1_n,
    input logic err_seen,
    input logic err_n
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> err_n);

    // R9
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> $stable(err_n));

    // R2
    err_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs0_n && cs1_n) && err_seen) |=> !err_n);

    // R7
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

    // R8
    no_false_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs0_n && cs1_n) && !err_seen && err_n) |=> err_n);

endmodule

bind cmd_parity_monitor cmd_parity_monitor_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs0_n    (cs0_n),
    .cs1_n    (cs1_n),
    .err_seen (err_seen),
    .err_n    (err_n)
);

// File: tb/cmd_parity_monitor_test.sv
module cmd_parity_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n, cfg_sel, par_in, cs0_n, cs1_n, gate_en;
    logic [27:0] cmd_in;
    logic        err_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state, derived from the requirements
    logic [27:0] m_d1, m_d2;
    logic        m_par, m_flag;
    int          m_cnt;

    always #10 clk = ~clk;

    cmd_parity_monitor uut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cmd_in(cmd_in),
        .par_in(par_in), .cs0_n(cs0_n), .cs1_n(cs1_n), .gate_en(gate_en),
        .err_n(err_n)
    );

    function automatic logic [27:0] cover_of(input logic c);
        logic [27:0] m = '0;
        for (int p = 1; p <= 28; p++) begin
            if (!c) m[p-1] = (p <= 5) || (p == 7) || (p >= 9 && p <= 12) || (p >= 17);
            else    m[p-1] = (p <= 12) || (p >= 17 && p <= 20) || (p == 22) || (p >= 24);
        end
        return m;
    endfunction

    task automatic chk(input string tag, input logic exp);
        n_run++;
        if (err_n !== exp) begin
            n_fail++;
            $display("FAIL %s: err_n=%b expected %b", tag, err_n, exp);
        end
    endtask

    task automatic chkm(input string tag);
        chk(tag, m_flag);
    endtask

    // drive one cycle from a falling edge, advance the model, return at the next falling edge
    task automatic drive(input logic [27:0] d, input logic p, input logic c0,
                         input logic c1, input logic ge);
        logic e;
        cmd_in = d; par_in = p; cs0_n = c0; cs1_n = c1; gate_en = ge;
        if (!rst_n) begin
            m_d1 = '0; m_d2 = '0; m_par = 1'b0; m_cnt = 0; m_flag = 1'b1;
        end else begin
            e = (^(m_d2 & cover_of(cfg_sel))) ^ m_par;
            if (!(c0 && c1)) begin
                if (e) m_cnt = 2;
                else if (m_cnt > 0) m_cnt--;
            end
            m_flag = (m_cnt == 0);
            m_d2   = m_d1;
            m_par  = p;
            if (!(ge && c0 && c1)) m_d1 = d;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [27:0] cov;
        rst_n = 1'b0; cfg_sel = 1'b0; cmd_in = '0; par_in = 1'b0;
        cs0_n = 1'b0; cs1_n = 1'b0; gate_en = 1'b0;
        @(negedge clk);
        idle(2);
        chk("R1 reset state", 1'b1);
        rst_n = 1'b1;

        for (int c = 0; c < 2; c++) begin
            cfg_sel = c[0];
            do_reset();
            cov = cover_of(cfg_sel);
            for (int i = 0; i < 28; i++) begin
                drive(28'd1 << i, 1'b0, 1'b0, 1'b0, 1'b0);
                drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
                chk("R4 no flag before n+2", 1'b1);
                drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
                chk(c ? "R6 cfg1 coverage" : "R5 cfg0 coverage", !cov[i]);
                idle(3);
                chk("R7 released after hold", 1'b1);
                drive(28'd1 << i, 1'b0, 1'b0, 1'b0, 1'b0);
                drive('0, cov[i], 1'b0, 1'b0, 1'b0);
                drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
                chk("R2 even weight passes", 1'b1);
                idle(1);
            end

            // R3: parity is paired with the word from the previous edge
            drive(28'd1, 1'b1, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R3 parity pairs with prior word", 1'b0);
            idle(5);

            // R7: minimum hold of two cycles
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R4 flag at n+2", 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R7 still low second cycle", 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R7 release", 1'b1);

            // R8: back-to-back errors
            for (int k = 0; k < 4; k++) drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 8; k++) begin
                drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
                chkm("R8 burst hold");
            end
            chk("R8 released after burst", 1'b1);

            // R9: freeze holds a low flag and hides a new error
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            idle(2);
            for (int k = 0; k < 5; k++) begin
                drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
                chk("R9 frozen low", 1'b0);
            end
            idle(3);
            chk("R9 released after freeze", 1'b1);
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
            drive('0, 1'b0, 1'b1, 1'b1, 1'b0);
            chk("R9 frozen ignores error", 1'b1);
            idle(3);
            chk("R9 quiet after freeze", 1'b1);

            // R10: error just before low-power mode
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            idle(2);
            for (int k = 0; k < 6; k++) begin
                drive('0, 1'b0, 1'b1, 1'b1, 1'b1);
                chk("R10 low through low power", 1'b0);
            end
            idle(1);
            chk("R10 low first cycle after", 1'b0);
            idle(1);
            chk("R10 release second cycle after", 1'b1);
            idle(2);

            // R11: word held in low-power mode
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b1, 1'b1, 1'b1, 1'b1);
            drive('0, 1'b1, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R11 held word checked", 1'b1);
            idle(1);
            chk("R11 no late error", 1'b1);
            idle(2);

            // R12: without gate enable the word is captured
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b1, 1'b1, 1'b1, 1'b0);
            drive('0, 1'b1, 1'b0, 1'b0, 1'b0);
            drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R12 ungated capture", 1'b0);
            idle(4);

            // R1: reset clears a held error
            drive(28'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            idle(2);
            rst_n = 1'b0;
            idle(1);
            rst_n = 1'b1;
            chk("R1 reset clears flag", 1'b1);
            idle(3);
            chk("R1 no leftover error", 1'b1);

            // randomized stream against the model
            for (int k = 0; k < 3000; k++) begin
                drive(28'($urandom), 1'($urandom), ($urandom % 3) == 0,
                      ($urandom % 3) == 0, 1'($urandom));
                chkm("R2 R9 R10 random stream");
            end
            idle(4);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule